// File: doc/BRIEF.md
# Two-Context Thread Switch Controller

This block decides which of two hardware thread contexts owns a single-issue pipeline front end. It holds one program counter for each context, presents the fetch address of the owning context, and reports the owner's id so that the pipeline can select the matching register file copy. The other context stays parked, and its saved PC is left untouched.

Ownership changes only when the owning context reports a long-latency miss, such as a cache or translation miss. Short stalls never cause a change. Ownership also changes when the owner has run for a programmable number of cycles, so that the parked context cannot starve. A change is made only when the parked context is ready, which means it has no miss outstanding. When a change is made, a one-cycle flush pulse goes out together with the new owner id and the new fetch address.

Top module: `coarse_thread_switch`

## Requirements
- R1: After reset, context 0 owns the pipeline, both saved PCs equal `reset_vec`, both contexts report ready, and `flush` is low.
- R2: `fetch_pc` always equals the saved PC of the owning context. `pc_ld[t]` loads `pc_ld_val<t>` into context t's PC at the next edge, whichever context owns the pipeline, and a load takes priority over an advance.
- R3: When `lat_miss` is raised for the owning context and the parked context is ready, ownership passes to the parked context at the next edge.
- R4: `short_stall` never changes ownership. While it is high, `pc_adv` of the owning context has no effect, so that context's PC holds.
- R5: With a nonzero run limit L, a context that has owned the pipeline for L consecutive cycles gives up ownership at the end of its L-th cycle, provided the parked context is ready. The limit register is written through `lim_we`/`lim_wdata` and takes effect from the cycle after the write. Its value after reset is the parameter LIMIT_RST.
- R6: A run limit of zero disables the timeout. Ownership then changes only through misses.
- R7: Ownership never passes to a context that has a miss outstanding. An owner with a pending miss keeps the pipeline until the parked context becomes ready, and ownership passes at the edge after that.
- R8: `flush` is high for exactly the one cycle in which a new owner id is first presented, and it is low in every other cycle.
- R9: `pc_adv` for the parked context is ignored, so the parked context's PC holds unless that context is loaded.
- R10: `thr_ready[t]` goes low at the edge after `lat_miss[t]` and goes high again at the edge after `miss_done[t]`. If both are raised in the same cycle, the miss wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reset_vec | input | PC_W | PC that both contexts take at reset |
| lim_we | input | 1 | Write strobe for the run limit |
| lim_wdata | input | CNT_W | New run limit; 0 disables the timeout |
| pc_ld | input | 2 | Per-context PC load strobe |
| pc_ld_val0 | input | PC_W | Load value for context 0 |
| pc_ld_val1 | input | PC_W | Load value for context 1 |
| pc_adv | input | 2 | Per-context advance request (PC += PC_INC) |
| short_stall | input | 1 | Short pipeline stall; holds the owning context's PC |
| lat_miss | input | 2 | Per-context long-latency miss raised |
| miss_done | input | 2 | Per-context miss resolved |
| act_tid | output | 1 | Owning context id (register file select) |
| fetch_pc | output | PC_W | Fetch address of the owning context |
| flush | output | 1 | One-cycle pulse when ownership changes |
| thr_pc0 | output | PC_W | Saved PC of context 0 |
| thr_pc1 | output | PC_W | Saved PC of context 1 |
| thr_ready | output | 2 | Per-context ready (no miss outstanding) |

## Verification
The hardest case to reach is the deferred switch. Both contexts must have misses outstanding, with the owner stuck on its own pending miss, and then the parked context's miss must resolve so that ownership passes one edge later and not at once. The directed stimulus builds this on purpose. It raises a miss on context 0 so that ownership moves to context 1, raises a second miss on context 1 while context 0 is still pending, and then resolves context 0. A behavioural model in the bench is compared on every cycle. A random phase follows that mixes miss, resolve, load, advance, short-stall and limit writes, and small limits make timeouts collide with misses.

// File: rtl/coarse_thread_switch.sv
module coarse_thread_switch #(
  parameter int PC_W      = 32,
  parameter int CNT_W     = 16,
  parameter int PC_INC    = 4,
  parameter int LIMIT_RST = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  reset_vec,
  input  logic             lim_we,
  input  logic [CNT_W-1:0] lim_wdata,
  input  logic [1:0]       pc_ld,
  input  logic [PC_W-1:0]  pc_ld_val0,
  input  logic [PC_W-1:0]  pc_ld_val1,
  input  logic [1:0]       pc_adv,
  input  logic             short_stall,
  input  logic [1:0]       lat_miss,
  input  logic [1:0]       miss_done,
  output logic             act_tid,
  output logic [PC_W-1:0]  fetch_pc,
  output logic             flush,
  output logic [PC_W-1:0]  thr_pc0,
  output logic [PC_W-1:0]  thr_pc1,
  output logic [1:0]       thr_ready
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [PC_W-1:0]  STEP    = PC_W'(PC_INC);

  logic             act_q, flush_q;
  logic [1:0]       pend_q;
  logic [CNT_W-1:0] cnt_q, lim_q;
  logic [PC_W-1:0]  pc0_q, pc1_q;

  wire oth     = ~act_q;
  wire oth_rdy = ~pend_q[oth];
  wire tmo     = (lim_q != '0) && (({1'b0, cnt_q} + 1'b1) >= {1'b0, lim_q});
  wire want    = lat_miss[act_q] | pend_q[act_q] | tmo;
  wire sw      = want & oth_rdy;
  wire step0   = pc_adv[0] & ~act_q & ~short_stall;
  wire step1   = pc_adv[1] &  act_q & ~short_stall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      flush_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      flush_q <= sw;
      if (sw) begin
        act_q <= oth;
        cnt_q <= '0;
      end else if (cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      lim_q <= CNT_W'(LIMIT_RST);
    else if (lim_we) lim_q <= lim_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 2'b00;
    end else begin
      for (int t = 0; t < 2; t++) begin
        if (lat_miss[t])       pend_q[t] <= 1'b1;
        else if (miss_done[t]) pend_q[t] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        pc0_q <= reset_vec;
    else if (pc_ld[0]) pc0_q <= pc_ld_val0;
    else if (step0)    pc0_q <= pc0_q + STEP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        pc1_q <= reset_vec;
    else if (pc_ld[1]) pc1_q <= pc_ld_val1;
    else if (step1)    pc1_q <= pc1_q + STEP;
  end

  assign act_tid   = act_q;
  assign flush     = flush_q;
  assign thr_pc0   = pc0_q;
  assign thr_pc1   = pc1_q;
  assign fetch_pc  = act_q ? pc1_q : pc0_q;
  assign thr_ready = ~pend_q;

  a_r8_flush_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_tid) |-> flush);
  a_r3_miss_switches: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_miss[act_tid] && thr_ready[~act_tid]) |=> flush);
  a_r7_no_busy_target: assert property (@(posedge clk) disable iff (!rst_n)
    !thr_ready[~act_tid] |=> $stable(act_tid));
  a_r6_zero_limit_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_q == '0 && !lat_miss[act_tid] && thr_ready[act_tid]) |=> $stable(act_tid));
  a_r9_parked_pc0_held: assert property (@(posedge clk) disable iff (!rst_n)
    (act_tid && !pc_ld[0]) |=> $stable(thr_pc0));
  a_r9_parked_pc1_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_tid && !pc_ld[1]) |=> $stable(thr_pc1));
  a_r4_stall_holds_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (short_stall && !pc_ld[act_tid] && !lat_miss[act_tid] && thr_ready[act_tid] && lim_q == '0)
      |=> $stable(fetch_pc));
endmodule

// File: tb/sim_coarse_thread_switch.sv
module sim_coarse_thread_switch;
  localparam int PC_W = 32, CNT_W = 16, PC_INC = 4, LIMIT_RST = 64;
  localparam logic [31:0] RVEC = 32'h0000_1000;

  logic clk = 0, rst_n = 0;
  logic [PC_W-1:0] reset_vec = RVEC;
  logic lim_we = 0;
  logic [CNT_W-1:0] lim_wdata = '0;
  logic [1:0] pc_ld = 0, pc_adv = 0, lat_miss = 0, miss_done = 0;
  logic [PC_W-1:0] pc_ld_val0 = 0, pc_ld_val1 = 0;
  logic short_stall = 0;
  logic act_tid, flush;
  logic [PC_W-1:0] fetch_pc, thr_pc0, thr_pc1;
  logic [1:0] thr_ready;

  int checks = 0, failures = 0;

  coarse_thread_switch #(.PC_W(PC_W), .CNT_W(CNT_W), .PC_INC(PC_INC), .LIMIT_RST(LIMIT_RST)) u0 (
    .clk(clk), .rst_n(rst_n), .reset_vec(reset_vec), .lim_we(lim_we), .lim_wdata(lim_wdata),
    .pc_ld(pc_ld), .pc_ld_val0(pc_ld_val0), .pc_ld_val1(pc_ld_val1), .pc_adv(pc_adv),
    .short_stall(short_stall), .lat_miss(lat_miss), .miss_done(miss_done),
    .act_tid(act_tid), .fetch_pc(fetch_pc), .flush(flush), .thr_pc0(thr_pc0),
    .thr_pc1(thr_pc1), .thr_ready(thr_ready));

  always #2.5 clk = ~clk;

  // behavioural reference
  int m_act, m_flush, m_cnt, m_lim;
  int m_pend[2];
  logic [31:0] m_pc[2];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_flush = 0; m_cnt = 0; m_lim = LIMIT_RST;
      m_pend[0] = 0; m_pend[1] = 0; m_pc[0] = reset_vec; m_pc[1] = reset_vec;
    end else begin
      int o, sw, want;
      o = 1 - m_act;
      want = lat_miss[m_act] || m_pend[m_act] || (m_lim != 0 && m_cnt + 1 >= m_lim);
      sw = want && !m_pend[o];
      for (int t = 0; t < 2; t++) begin
        if (pc_ld[t]) m_pc[t] = (t == 0) ? pc_ld_val0 : pc_ld_val1;
        else if (pc_adv[t] && m_act == t && !short_stall) m_pc[t] = m_pc[t] + PC_INC;
      end
      for (int t = 0; t < 2; t++) begin
        if (lat_miss[t]) m_pend[t] = 1;
        else if (miss_done[t]) m_pend[t] = 0;
      end
      if (lim_we) m_lim = lim_wdata;
      m_flush = sw;
      if (sw) begin m_act = o; m_cnt = 0; end
      else if (m_cnt < 65535) m_cnt = m_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R3 act_tid", 32'(act_tid), 32'(m_act));
    chk("R2 fetch_pc", fetch_pc, m_pc[m_act]);
    chk("R8 flush", 32'(flush), 32'(m_flush));
    chk("R9 thr_pc0", thr_pc0, m_pc[0]);
    chk("R9 thr_pc1", thr_pc1, m_pc[1]);
    chk("R10 thr_ready", 32'(thr_ready), 32'({m_pend[1] == 0, m_pend[0] == 0}));
  end

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle();
    lim_we = 0; pc_ld = 0; pc_adv = 0; lat_miss = 0; miss_done = 0; short_stall = 0;
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int run;
    logic [31:0] p0;
    cyc(3); rst_n = 1; cyc(1);
    // R1 reset state
    chk("R1 act", 32'(act_tid), 0);
    chk("R1 pc0", thr_pc0, RVEC);
    chk("R1 pc1", thr_pc1, RVEC);
    chk("R1 ready", 32'(thr_ready), 3);
    chk("R1 flush", 32'(flush), 0);

    // R6 zero limit: no timeout
    lim_we = 1; lim_wdata = 0; cyc(1); lim_we = 0;
    pc_adv = 2'b01; cyc(80);
    chk("R6 no timeout", 32'(act_tid), 0);
    chk("R2 advance", thr_pc0, RVEC + 32'(80 * PC_INC));

    // R4 short stall: no switch, PC held
    p0 = thr_pc0; short_stall = 1; cyc(6);
    chk("R4 pc held", thr_pc0, p0);
    chk("R4 no switch", 32'(act_tid), 0);
    short_stall = 0; idle();

    // R3 miss switches, R8 pulse
    lat_miss = 2'b01; cyc(1); lat_miss = 0;
    chk("R3 switched", 32'(act_tid), 1);
    chk("R8 pulse", 32'(flush), 1);
    chk("R10 ready0 low", 32'(thr_ready[0]), 0);
    p0 = thr_pc0; pc_adv = 2'b11; cyc(1);
    chk("R8 single", 32'(flush), 0);
    cyc(3); pc_adv = 0;
    chk("R9 parked pc0", thr_pc0, p0);

    // R7 both pending: hold, then deferred switch
    lat_miss = 2'b10; cyc(1); lat_miss = 0; cyc(3);
    chk("R7 held", 32'(act_tid), 1);
    miss_done = 2'b01; cyc(1); miss_done = 0;
    chk("R7 not yet", 32'(act_tid), 1);
    cyc(1);
    chk("R7 deferred", 32'(act_tid), 0);
    miss_done = 2'b10; cyc(1); idle();

    // R2 load of parked context
    pc_ld = 2'b10; pc_ld_val1 = 32'h0000_8000; cyc(1); pc_ld = 0;
    chk("R2 load parked", thr_pc1, 32'h0000_8000);

    // R5 timeout after 5 cycles
    lim_we = 1; lim_wdata = 5; cyc(1); lim_we = 0;
    while (!flush) cyc(1);
    run = 0;
    do begin run++; cyc(1); end while (!flush && run < 100);
    chk("R5 run length", 32'(run), 5);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 100;
      lat_miss  = 2'($urandom % 16 == 0 ? ($urandom % 3) + 1 : 0);
      miss_done = 2'($urandom % 4 == 0 ? ($urandom % 3) + 1 : 0);
      pc_adv    = 2'($urandom % 4);
      short_stall = ($urandom % 5 == 0);
      pc_ld     = 2'($urandom % 12 == 0 ? ($urandom % 3) + 1 : 0);
      pc_ld_val0 = $urandom; pc_ld_val1 = $urandom;
      lim_we    = (r < 3);
      lim_wdata = 16'($urandom % 13);
      cyc(1);
    end
    idle(); cyc(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule